// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a bus of dual-rail signals and reports, on a single registered `done` flag, when every signal on the bus carries a valid codeword. Each signal is a pair of wires: a "high" rail and a "low" rail. A value of 0 is the pair {high,low} = {0,1} and a value of 1 is {1,0}. One of the two remaining combinations is the empty (spacer) state that separates successive codewords. The other combination is forbidden.

A per-signal detector turns each pair into a single "complete" bit. The detector is an OR of the two rails when the spacer is all-zeroes, and a NAND of the two rails when the spacer is all-ones. It deliberately does not use an XOR, because a correct datapath never drives the forbidden state. Balanced reduction trees combine the per-signal bits.

A build-time choice selects how the trees are joined into `done`:
- **Hold join.** This is a Muller-style join modelled with a clocked hold register. It raises `done` when every signal is complete. It drops `done` only when every signal has returned to spacer, and holds in between.
- **Plain AND join.** This follows only the all-complete condition. It relies on the assumption that enough idle time passes for every rail to return to spacer before the next codeword.

A separate registered `fault` flag reports any pair sitting in the forbidden state.

Top module: `dr_completion_tree`

## Requirements
- R1: While `rst` is high at a rising edge, `done` and `fault` are 0 after that edge.
- R2: With the all-zeroes spacer, {high,low} = {0,0} is spacer, {1,1} is forbidden, and a pair counts as complete when either rail is 1.
- R3: With the all-ones spacer, {1,1} is spacer, {0,0} is forbidden, and a pair counts as complete unless both rails are 1.
- R4: In hold mode, `done` is 1 after any edge at which every pair was complete.
- R5: In hold mode, `done` falls only after an edge at which every pair was spacer. In either mode, an all-spacer input gives `done` = 0 after the next edge.
- R6: In hold mode, when some but not all pairs are complete, `done` keeps its previous value.
- R7: In AND mode, `done` after an edge equals "all pairs complete" at that edge. It therefore rises again for a new codeword even if some pair never returned to spacer.
- R8: `fault` is 1 after an edge at which at least one pair was in the forbidden state, and 0 otherwise.
- R9: A forbidden pair counts as complete for the `done` logic.
- R10: Both outputs are registered and reflect the inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_hi | input | WIDTH | High rail of each dual-rail signal |
| rail_lo | input | WIDTH | Low rail of each dual-rail signal |
| done | output | 1 | Registered completion flag |
| fault | output | 1 | Registered forbidden-state flag |

## Verification
The bench builds four copies of the block with WIDTH = 5, one for each combination of join style and spacer polarity. All four are fed the same logical stimulus, which is encoded per polarity. An odd width forces the reduction trees to pad unused leaves, so the padding values of both trees are exercised. Running the four copies side by side shows the two joins diverging on partially returned spacers and stragglers, and shows both polarities agreeing on every codeword.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int JOIN_HOLD = 0;
  localparam int JOIN_AND  = 1;

  localparam int SPACER_ZERO = 0;
  localparam int SPACER_ONE  = 1;

  localparam int OP_AND = 0;
  localparam int OP_OR  = 1;

  function automatic int tree_levels(input int width);
    return (width <= 1) ? 0 : $clog2(width);
  endfunction
endpackage

// File: rtl/dr_pair_detect.sv
module dr_pair_detect #(
  parameter int SPACER_ONES = 0
) (
  input  logic hi,
  input  logic lo,
  output logic complete,
  output logic forbidden
);
  generate
    if (SPACER_ONES != 0) begin : g_ones
      assign complete  = ~(hi & lo);
      assign forbidden = ~(hi | lo);
    end else begin : g_zero
      assign complete  = hi | lo;
      assign forbidden = hi & lo;
    end
  endgenerate
endmodule

// File: rtl/dr_reduce_tree.sv
module dr_reduce_tree #(
  parameter int WIDTH = 8,
  parameter int OP    = 0
) (
  input  logic [WIDTH-1:0] leaves,
  output logic             root
);
  import dr_pkg::*;

  localparam int LEVELS = tree_levels(WIDTH);
  localparam int SLOTS  = 1 << LEVELS;
  localparam int NODES  = 2 * SLOTS - 1;
  localparam logic PAD  = (OP == OP_OR) ? 1'b0 : 1'b1;

  logic [NODES-1:0] node;

  genvar i;
  generate
    for (i = 0; i < SLOTS; i++) begin : g_leaf
      if (i < WIDTH) begin : g_real
        assign node[SLOTS-1+i] = leaves[i];
      end else begin : g_pad
        assign node[SLOTS-1+i] = PAD;
      end
    end
    for (i = 0; i < SLOTS - 1; i++) begin : g_inner
      if (OP == OP_OR) begin : g_or
        assign node[i] = node[2*i+1] | node[2*i+2];
      end else begin : g_and
        assign node[i] = node[2*i+1] & node[2*i+2];
      end
    end
  endgenerate

  assign root = node[0];
endmodule

// File: rtl/dr_join.sv
module dr_join #(
  parameter int JOIN_MODE = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic all_valid,
  input  logic all_empty,
  output logic done
);
  import dr_pkg::*;

  logic done_q;
  logic done_d;

  generate
    if (JOIN_MODE == JOIN_AND) begin : g_and
      assign done_d = all_valid;
      logic unused_empty;
      assign unused_empty = all_empty;
    end else begin : g_hold
      always_comb begin
        if (all_valid)      done_d = 1'b1;
        else if (all_empty) done_d = 1'b0;
        else                done_d = done_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= done_d;
  end

  assign done = done_q;
endmodule

// File: rtl/dr_completion_tree.sv
module dr_completion_tree #(
  parameter int WIDTH       = 8,
  parameter int JOIN_MODE   = 0,
  parameter int SPACER_ONES = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] rail_hi,
  input  logic [WIDTH-1:0] rail_lo,
  output logic             done,
  output logic             fault
);
  import dr_pkg::*;

  logic [WIDTH-1:0] bit_ok;
  logic [WIDTH-1:0] bit_bad;
  logic             all_valid;
  logic             any_valid;
  logic             any_bad;
  logic             fault_q;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      dr_pair_detect #(.SPACER_ONES(SPACER_ONES)) det_i (
        .hi        (rail_hi[b]),
        .lo        (rail_lo[b]),
        .complete  (bit_ok[b]),
        .forbidden (bit_bad[b])
      );
    end
  endgenerate

  dr_reduce_tree #(.WIDTH(WIDTH), .OP(OP_AND)) valid_tree_i (
    .leaves (bit_ok),
    .root   (all_valid)
  );

  dr_reduce_tree #(.WIDTH(WIDTH), .OP(OP_OR)) empty_tree_i (
    .leaves (bit_ok),
    .root   (any_valid)
  );

  dr_reduce_tree #(.WIDTH(WIDTH), .OP(OP_OR)) bad_tree_i (
    .leaves (bit_bad),
    .root   (any_bad)
  );

  dr_join #(.JOIN_MODE(JOIN_MODE)) join_i (
    .clk       (clk),
    .rst       (rst),
    .all_valid (all_valid),
    .all_empty (~any_valid),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= any_bad;
  end

  assign fault = fault_q;
endmodule

// File: rtl/dr_completion_tree_chk.sv
module dr_completion_tree_chk #(
  parameter int WIDTH       = 8,
  parameter int JOIN_MODE   = 0,
  parameter int SPACER_ONES = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] rail_hi,
  input logic [WIDTH-1:0] rail_lo,
  input logic             done,
  input logic             fault
);
  logic sp_hi;
  logic all_ok;
  logic all_sp;
  logic any_forb;

  assign sp_hi = (SPACER_ONES != 0);

  always_comb begin
    all_ok   = 1'b1;
    all_sp   = 1'b1;
    any_forb = 1'b0;
    for (int k = 0; k < WIDTH; k++) begin
      if (rail_hi[k] == sp_hi && rail_lo[k] == sp_hi) all_ok = 1'b0;
      else                                            all_sp = 1'b0;
      if (rail_hi[k] == !sp_hi && rail_lo[k] == !sp_hi) any_forb = 1'b1;
    end
  end

  // R1
  rst_clears_chk: assert property (@(posedge clk) rst |=> (!done && !fault));

  // R8
  fault_set_chk: assert property (@(posedge clk) disable iff (rst)
    any_forb |=> fault);

  // R8
  fault_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !any_forb |=> !fault);

  // R5
  empty_drops_chk: assert property (@(posedge clk) disable iff (rst)
    all_sp |=> !done);

  // R4
  full_raises_chk: assert property (@(posedge clk) disable iff (rst)
    all_ok |=> done);

  generate
    if (JOIN_MODE == 0) begin : g_hold
      // R6
      mixed_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!all_ok && !all_sp) |=> $stable(done));
      // R5
      fall_after_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> $past(all_sp));
    end else begin : g_and
      // R7
      partial_low_chk: assert property (@(posedge clk) disable iff (rst)
        !all_ok |=> !done);
    end
  endgenerate
endmodule

bind dr_completion_tree dr_completion_tree_chk #(
  .WIDTH(WIDTH), .JOIN_MODE(JOIN_MODE), .SPACER_ONES(SPACER_ONES)
) chk_i (.*);

// File: tb/dr_completion_tree_tb_top.sv
`timescale 1ns/1ps
module dr_completion_tree_tb_top;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  // logical state per signal: 0 spacer, 1 value0, 2 value1, 3 forbidden
  logic [1:0] st [W];
  logic [W-1:0] zhi, zlo, ohi, olo;
  logic d_hz, d_az, d_ho, d_ao, f_hz, f_az, f_ho, f_ao;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;
  logic exp_hold = 1'b0;

  function automatic logic [1:0] enc(input logic [1:0] s, input bit ones);
    case (s)
      2'd0:    return ones ? 2'b11 : 2'b00;
      2'd1:    return 2'b01;
      2'd2:    return 2'b10;
      default: return ones ? 2'b00 : 2'b11;
    endcase
  endfunction

  always_comb begin
    for (int k = 0; k < W; k++) begin
      {zhi[k], zlo[k]} = enc(st[k], 1'b0);
      {ohi[k], olo[k]} = enc(st[k], 1'b1);
    end
  end

  dr_completion_tree #(.WIDTH(W), .JOIN_MODE(0), .SPACER_ONES(0)) dut_i (
    .clk(clk), .rst(rst), .rail_hi(zhi), .rail_lo(zlo), .done(d_hz), .fault(f_hz));
  dr_completion_tree #(.WIDTH(W), .JOIN_MODE(1), .SPACER_ONES(0)) dut_and_zero_i (
    .clk(clk), .rst(rst), .rail_hi(zhi), .rail_lo(zlo), .done(d_az), .fault(f_az));
  dr_completion_tree #(.WIDTH(W), .JOIN_MODE(0), .SPACER_ONES(1)) dut_hold_ones_i (
    .clk(clk), .rst(rst), .rail_hi(ohi), .rail_lo(olo), .done(d_ho), .fault(f_ho));
  dr_completion_tree #(.WIDTH(W), .JOIN_MODE(1), .SPACER_ONES(1)) dut_and_ones_i (
    .clk(clk), .rst(rst), .rail_hi(ohi), .rail_lo(olo), .done(d_ao), .fault(f_ao));

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Drive at a falling edge, one rising edge passes (R10), sample at the next falling edge.
  task automatic step(input logic [1:0] s [W]);
    bit ok, empty, bad;
    string sit, r9;
    @(negedge clk);
    for (int k = 0; k < W; k++) st[k] = s[k];
    ok = 1; empty = 1; bad = 0;
    for (int k = 0; k < W; k++) begin
      if (s[k] == 2'd0) ok = 0; else empty = 0;
      if (s[k] == 2'd3) bad = 1;
    end
    exp_hold = ok ? 1'b1 : (empty ? 1'b0 : exp_hold);
    sit = ok ? "R4" : (empty ? "R5" : "R6");
    r9  = bad ? " R9" : "";
    @(negedge clk);
    check({sit, " R2 R10 hold/zero done", r9}, d_hz, exp_hold);
    check({sit, " R3 R10 hold/ones done", r9}, d_ho, exp_hold);
    check({"R7 R2 R10 and/zero done", r9}, d_az, ok);
    check({"R7 R3 R10 and/ones done", r9}, d_ao, ok);
    check("R8 R2 zero fault (hold)", f_hz, bad);
    check("R8 R2 zero fault (and)",  f_az, bad);
    check("R8 R3 ones fault (hold)", f_ho, bad);
    check("R8 R3 ones fault (and)",  f_ao, bad);
  endtask

  task automatic fill(input logic [1:0] v, output logic [1:0] s [W]);
    for (int k = 0; k < W; k++) s[k] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [1:0] s [W];
    void'($urandom(32'h5eed_0001));
    for (int k = 0; k < W; k++) st[k] = 2'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with valid data applied
    check("R1 hold/zero done", d_hz, 1'b0);
    check("R1 and/ones done", d_ao, 1'b0);
    check("R1 hold/zero fault", f_hz, 1'b0);
    check("R1 and/ones fault", f_ao, 1'b0);
    rst = 1'b0;
    exp_hold = 1'b0;

    fill(2'd0, s); step(s);                        // all spacer
    s = '{2'd1, 2'd2, 2'd2, 2'd1, 2'd2}; step(s);  // R4 full codeword
    s[3] = 2'd0; step(s);                          // R6 hold stays 1, R7 drops
    s[3] = 2'd2; step(s);                          // R7 straggler re-raise
    fill(2'd0, s); s[0] = 2'd1; step(s);           // R6 straggler, hold stays 1
    fill(2'd0, s); step(s);                        // R5 all spacer, fall
    s[4] = 2'd2; step(s);                          // R6 partial, hold stays 0
    fill(2'd1, s); s[2] = 2'd3; step(s);           // R9 forbidden counts complete, R8
    fill(2'd0, s); s[1] = 2'd3; step(s);           // R8 forbidden alone
    fill(2'd0, s); step(s);
    fill(2'd1, s); step(s);                        // all value 0
    fill(2'd2, s); step(s);                        // all value 1, no spacer between

    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 3);
      for (int k = 0; k < W; k++) begin
        case (kind)
          0: s[k] = 2'd0;
          1: s[k] = 2'($urandom_range(1, 2));
          default: s[k] = 2'($urandom_range(0, 2));
        endcase
        if ($urandom_range(0, 31) == 0) s[k] = 2'd3;
      end
      step(s);
    end

    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 hold/ones done after reset", d_ho, 1'b0);
    check("R1 and/zero fault after reset", f_az, 1'b0);

    finished = 1;
    report();
    $finish;
  end
endmodule